// File: doc/BRIEF.md
# Receiving-Side Pausable-Clock Handshake Controller

This controller sits on the passive end of a bidirectional four-phase link between two locally clocked modules. Local logic opens the port with a port enable. The remote module asks for a transfer with a request line. The controller asks its own clock generator to stop only when both the enable and the remote request are present. When the generator reports that the clock is stopped, the controller acknowledges the remote side and tells local logic that the transfer has happened. When the remote request is withdrawn, the controller lets the clock run again. It then waits for the generator to confirm the release before it drops its acknowledge.

All three inputs pass through a flop synchronizer with `SYNC_STAGES` stages. A Moore state machine runs on the synchronized values. Its states are IDLE, PAUSE, GRANT, RELEASE and HOLD. The transitions are:
- IDLE→PAUSE when enable and request are both high.
- PAUSE→GRANT when the pause acknowledge rises.
- GRANT→RELEASE when the request falls.
- RELEASE→HOLD when the pause acknowledge falls.
- HOLD→IDLE when the enable falls.

A sticky error flag records any input change that does not fit the handshake.

Top module: `prx_port`

## Requirements
- R1: While reset is low, and in the first cycle after it, `pause_req`, `rmt_ack`, `xfer_done` and `seq_err` are 0, and the machine is in IDLE.
- R2: `pause_req` rises only after synchronized `port_en` and `rmt_req` have both been seen high. The two may arrive in either order. `pause_req` stays high through PAUSE and GRANT.
- R3: When synchronized `pause_ack` is high in PAUSE, `rmt_ack` and `xfer_done` both rise on the next clock (PAUSE→GRANT).
- R4: When synchronized `rmt_req` is low in GRANT, `pause_req` falls on the next clock and `rmt_ack` stays high (GRANT→RELEASE).
- R5: When synchronized `pause_ack` is low in RELEASE, `rmt_ack` falls on the next clock and `xfer_done` stays high (RELEASE→HOLD).
- R6: `xfer_done` stays high until synchronized `port_en` is low in HOLD. It then falls on the next clock and the machine returns to IDLE.
- R7: A `rmt_req` that arrives while `port_en` is low is held pending. It does not raise `pause_req`. It takes effect once `port_en` rises, as long as the request is still present.
- R8: `seq_err` becomes 1 on the clock after an out-of-order synchronized input. The out-of-order cases are:
  - `pause_ack` high in IDLE or HOLD;
  - `rmt_req` or `port_en` low in PAUSE;
  - `pause_ack` or `port_en` low in GRANT;
  - `rmt_req` high or `port_en` low in RELEASE.
  Once set, `seq_err` stays 1 until reset.
- R9: An input change applied between clock edges reaches the outputs after `SYNC_STAGES`+1 rising edges. With the default of 2, that is 3 edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Local port enable |
| rmt_req | input | 1 | Request from the remote module |
| pause_ack | input | 1 | Clock generator reports the clock is paused |
| pause_req | output | 1 | Asks the clock generator to pause |
| rmt_ack | output | 1 | Acknowledge to the remote module |
| xfer_done | output | 1 | Transfer taken, to local logic |
| seq_err | output | 1 | Sticky handshake-order error |

## Verification
The assertions check every cycle that each output edge follows the synchronized input that permits it:
- the pause request rises only after the join of enable and request, and falls only after the request has dropped;
- the acknowledge follows the pause acknowledge on both edges;
- the done signal falls only after the enable has gone;
- the error flag never clears.

Other behaviours can only be shown by the bench's scenarios:
- the pending request while the port is closed;
- both arrival orders;
- the exact synchronizer latency;
- the error flag being set by an injected out-of-order pause acknowledge and cleared by reset.

// File: rtl/prx_pkg.sv
package prx_pkg;
    localparam int unsigned IN_W = 3;
    localparam int unsigned IDX_EN  = 2;
    localparam int unsigned IDX_REQ = 1;
    localparam int unsigned IDX_AI  = 0;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_PAUSE   = 3'd1,
        ST_GRANT   = 3'd2,
        ST_RELEASE = 3'd3,
        ST_HOLD    = 3'd4
    } prx_state_e;

    typedef struct packed {
        logic pause_req;
        logic rmt_ack;
        logic xfer_done;
    } prx_out_s;
endpackage

// File: rtl/prx_sync.sv
module prx_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    localparam int unsigned LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[g] <= '0;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[LAST];
endmodule

// File: rtl/prx_fsm.sv
module prx_fsm
    import prx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_s,
    input  logic     req_s,
    input  logic     ai_s,
    output prx_out_s outs,
    output logic     err_q
);
    prx_state_e state_q, state_d;
    logic       bad_seq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        bad_seq = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                bad_seq = ai_s;
                if (en_s && req_s) state_d = ST_PAUSE;
            end
            ST_PAUSE: begin
                bad_seq = !req_s || !en_s;
                if (ai_s) state_d = ST_GRANT;
            end
            ST_GRANT: begin
                bad_seq = !ai_s || !en_s;
                if (!req_s) state_d = ST_RELEASE;
            end
            ST_RELEASE: begin
                bad_seq = req_s || !en_s;
                if (!ai_s) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                bad_seq = ai_s;
                if (!en_s) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        outs = '0;
        unique case (state_q)
            ST_IDLE:    outs = '0;
            ST_PAUSE:   outs.pause_req = 1'b1;
            ST_GRANT: begin
                outs.pause_req = 1'b1;
                outs.rmt_ack   = 1'b1;
                outs.xfer_done = 1'b1;
            end
            ST_RELEASE: begin
                outs.rmt_ack   = 1'b1;
                outs.xfer_done = 1'b1;
            end
            ST_HOLD:    outs.xfer_done = 1'b1;
            default:    outs = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= err_q | bad_seq;
    end
endmodule

// File: rtl/prx_port.sv
module prx_port
    import prx_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_en,
    input  logic rmt_req,
    input  logic pause_ack,
    output logic pause_req,
    output logic rmt_ack,
    output logic xfer_done,
    output logic seq_err
);
    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] sync_in;
    logic            en_s, req_s, ai_s;
    prx_out_s        outs;

    assign raw_in[IDX_EN]  = port_en;
    assign raw_in[IDX_REQ] = rmt_req;
    assign raw_in[IDX_AI]  = pause_ack;

    prx_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_in)
    );

    assign en_s  = sync_in[IDX_EN];
    assign req_s = sync_in[IDX_REQ];
    assign ai_s  = sync_in[IDX_AI];

    prx_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .en_s  (en_s),
        .req_s (req_s),
        .ai_s  (ai_s),
        .outs  (outs),
        .err_q (seq_err)
    );

    assign pause_req = outs.pause_req;
    assign rmt_ack   = outs.rmt_ack;
    assign xfer_done = outs.xfer_done;
endmodule

// File: rtl/prx_port_chk.sv
module prx_port_chk (
    input logic clk,
    input logic rst_n,
    input logic en_s,
    input logic req_s,
    input logic ai_s,
    input logic pause_req,
    input logic rmt_ack,
    input logic xfer_done,
    input logic seq_err
);
    // R2
    ri_join_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pause_req) |-> ($past(en_s) && $past(req_s)));

    // R3
    ack_after_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rmt_ack) |-> ($past(ai_s) && xfer_done));

    // R4
    ri_drop_on_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pause_req) |-> (!$past(req_s) && rmt_ack));

    // R5
    ack_rtz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rmt_ack) |-> !$past(ai_s));

    // R6
    ta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_done) |-> !$past(en_s));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> seq_err);

    // R3
    ack_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rmt_ack |-> xfer_done);
endmodule

bind prx_port prx_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_s      (en_s),
    .req_s     (req_s),
    .ai_s      (ai_s),
    .pause_req (pause_req),
    .rmt_ack   (rmt_ack),
    .xfer_done (xfer_done),
    .seq_err   (seq_err)
);

// File: tb/sim_prx_port.sv
module sim_prx_port;
    localparam int NSYNC = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, req = 1'b0, ai = 1'b0;
    logic ri, ack, ta, err;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    prx_port #(.SYNC_STAGES(NSYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .port_en(en), .rmt_req(req), .pause_ack(ai),
        .pause_req(ri), .rmt_ack(ack), .xfer_done(ta), .seq_err(err)
    );

    // behavioural reference: delay queue plus phase counter
    logic [2:0] dq[$];
    int   ph = 0;
    bit   m_err = 0;

    initial begin
        for (int i = 0; i < NSYNC; i++) dq.push_back(3'b000);
    end

    always @(posedge clk) begin
        logic [2:0] v;
        bit e, r, a;
        if (!rst_n) begin
            ph = 0; m_err = 0;
            dq.delete();
            for (int i = 0; i < NSYNC; i++) dq.push_back(3'b000);
        end else begin
            v = dq.pop_front();
            e = v[2]; r = v[1]; a = v[0];
            if ((ph == 0 && a) || (ph == 1 && (!r || !e)) || (ph == 2 && (!a || !e)) ||
                (ph == 3 && (r || !e)) || (ph == 4 && a)) m_err = 1;
            if      (ph == 0 && e && r) ph = 1;
            else if (ph == 1 && a)      ph = 2;
            else if (ph == 2 && !r)     ph = 3;
            else if (ph == 3 && !a)     ph = 4;
            else if (ph == 4 && !e)     ph = 0;
            dq.push_back({en, req, ai});
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 pause_req model", ri,  (ph == 1 || ph == 2));
            chk("R3 rmt_ack model",   ack, (ph == 2 || ph == 3));
            chk("R6 xfer_done model", ta,  (ph >= 2));
            chk("R8 seq_err model",   err, m_err);
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic full_return(input string tag);
        ai = 1; cyc(4);
        chk({tag, " R3 ack"}, ack, 1); chk({tag, " R3 done"}, ta, 1);
        req = 0; cyc(4);
        chk({tag, " R4 ri"}, ri, 0); chk({tag, " R4 ack"}, ack, 1);
        ai = 0; cyc(4);
        chk({tag, " R5 ack"}, ack, 0); chk({tag, " R5 done"}, ta, 1);
        cyc(3);
        chk({tag, " R6 held"}, ta, 1);
        en = 0; cyc(4);
        chk({tag, " R6 done"}, ta, 0); chk({tag, " R6 ri"}, ri, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        cyc(2);
        chk("R1 ri rst", ri, 0); chk("R1 ack rst", ack, 0);
        chk("R1 done rst", ta, 0); chk("R1 err rst", err, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 ri idle", ri, 0);

        // request first, port closed: pending
        req = 1; cyc(8);
        chk("R7 no pause while closed", ri, 0);
        en = 1; cyc(4);
        chk("R7 pending taken R2", ri, 1);
        chk("R2 ack low in pause", ack, 0);
        full_return("seqA");

        // enable first, then request
        en = 1; cyc(6);
        chk("R2 enable alone", ri, 0);
        req = 1; cyc(4);
        chk("R2 join", ri, 1);
        full_return("seqB");

        // latency: both together
        en = 1; req = 1;
        cyc(NSYNC);
        chk("R9 before latency", ri, 0);
        cyc(1);
        chk("R9 at latency", ri, 1);
        full_return("seqC");
        chk("R8 clean run", err, 0);

        // out-of-order pause_ack while idle
        ai = 1; cyc(4);
        chk("R8 err set", err, 1);
        chk("R8 no pause from stray ack", ri, 0);
        ai = 0; cyc(6);
        chk("R8 err sticky", err, 1);
        rst_n = 0; cyc(2);
        chk("R1 err cleared by reset", err, 0);
        rst_n = 1; cyc(3);
        chk("R1 idle after reset", ta, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule